// File: doc/BRIEF.md
# Conversion Start and Busy Sequencer

This block runs the control side of a successive-approximation converter. It watches an active-low start request and raises a busy flag for the length of one conversion. At the end of that conversion it captures the result word presented on its data input, and it then enforces an acquisition interval before another conversion can begin. A cycle counter of fixed length stands in for the bit-by-bit conversion. Analog sampling and the bit decisions are left to logic outside the block.

The start request is synchronised and then edge-detected. Three inputs change how conversions are scheduled:
- A synchronous reset abandons a conversion that is in flight without touching the stored result.
- Power-down lets a running conversion finish and then blocks any new one.
- In impulse mode, a start request that is still held low when acquisition ends launches the next conversion at once.

Downstream logic can take the result either on the falling edge of busy or on the one-cycle ready strobe.

Top module: `cnv_sequencer`

## Requirements
- R1: When `start_n` falls while the block is idle and `pwr_dn` is low, `busy` goes high. `busy` is first seen high SYNC_STAGES+1 clock edges after the first edge that samples `start_n` low.
- R2: Once a conversion has started, `busy` stays high for exactly CONV_CYCLES clock cycles, unless reset cuts it short.
- R3: After a completed conversion, `data_rdy` is high for exactly one cycle, which is the first cycle in which `busy` is low. In that cycle `result` equals the value `conv_data` held during the last busy cycle.
- R4: `result` changes only in a cycle where `data_rdy` is high.
- R5: Falling edges on `start_n` while `busy` is high are ignored. They neither lengthen the conversion nor start a further one.
- R6: An acquisition interval of ACQ_CYCLES cycles follows every completed conversion, and also follows reset. Start edges that fall inside it are ignored, so `busy` stays low for at least ACQ_CYCLES cycles between conversions.
- R7: A high `rst` aborts any conversion. `busy` and `data_rdy` are low in the following cycle, no ready strobe is issued for the aborted conversion, and `result` keeps its previous value.
- R8: Raising `pwr_dn` during a conversion does not shorten it. The conversion completes with its normal ready strobe and result.
- R9: While `pwr_dn` is high, no new conversion starts, whether from a start edge or from impulse mode.
- R10: With `impulse_en` high, if `start_n` is still low when acquisition ends, the next conversion starts immediately. `busy` is then low for exactly ACQ_CYCLES cycles between the two conversions.
- R11: With `impulse_en` low, a `start_n` held low across the end of acquisition does not start a conversion. Only a new falling edge does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset and conversion abort |
| start_n | input | 1 | Active-low conversion start request |
| pwr_dn | input | 1 | Power-down: inhibit new conversions |
| impulse_en | input | 1 | Impulse mode select: auto-start on held request |
| conv_data | input | DATA_W | Result word from the conversion datapath |
| busy | output | 1 | High while a conversion is running |
| result | output | DATA_W | Latched result of the last completed conversion |
| data_rdy | output | 1 | One-cycle strobe when a new result is latched |

## Verification
The assertions check the cycle-level rules on every cycle:
- the ready strobe is single-cycle and tied to the falling edge of busy;
- the result is stable between strobes and matches the data captured;
- busy runs for exactly CONV_CYCLES;
- the low gap before a new busy is at least ACQ_CYCLES;
- no conversion begins while power-down is high;
- reset clears busy and the strobe.

Only the bench scenarios can show the behaviours below, because each depends on a specific stimulus history:
- start-to-busy latency;
- that edges during busy or during acquisition are dropped;
- that an aborted conversion leaves the old result in place;
- the impulse-mode back-to-back gap;
- that a held request without impulse mode never restarts.

// File: rtl/cnv_pkg.sv
package cnv_pkg;

  typedef enum logic [1:0] {
    ST_ACQ  = 2'd0,
    ST_IDLE = 2'd1,
    ST_CONV = 2'd2
  } cnv_state_e;

  function automatic int unsigned cnv_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cnv_start_sync.sv
module cnv_start_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_n_i,
  output logic level_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // Synchroniser chain; idle level of the request is high.
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b1;
          else     sync_q[0] <= req_n_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[i] <= 1'b1;
          else     sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign level_o = sync_q[STAGES-1];
  assign fall_o  = prev_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/cnv_timer.sv
module cnv_timer #(
  parameter int unsigned CONV_CYCLES = 18,
  parameter int unsigned ACQ_CYCLES  = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic load_conv_i,
  input  logic load_acq_i,
  output logic expired_o
);

  localparam int unsigned MAX_CNT = cnv_pkg::cnv_max(CONV_CYCLES, ACQ_CYCLES);
  localparam int unsigned CNT_W   = (MAX_CNT < 2) ? 1 : $clog2(MAX_CNT);
  localparam logic [CNT_W-1:0] CONV_LOAD = CNT_W'(CONV_CYCLES - 1);
  localparam logic [CNT_W-1:0] ACQ_LOAD  = CNT_W'(ACQ_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  // Reset starts an acquisition window, the same as the end of a conversion.
  always_ff @(posedge clk) begin
    if (rst)                   cnt_q <= ACQ_LOAD;
    else if (load_conv_i)      cnt_q <= CONV_LOAD;
    else if (load_acq_i)       cnt_q <= ACQ_LOAD;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/cnv_result_reg.sv
module cnv_result_reg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] result_o,
  output logic              rdy_o
);

  // The result word has no reset, so an abort leaves the last value intact.
  always_ff @(posedge clk) begin
    if (capture_i && !rst) result_o <= data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) rdy_o <= 1'b0;
    else     rdy_o <= capture_i;
  end

endmodule

// File: rtl/cnv_sequencer.sv
module cnv_sequencer #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CONV_CYCLES = 18,
  parameter int unsigned ACQ_CYCLES  = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_n,
  input  logic              pwr_dn,
  input  logic              impulse_en,
  input  logic [DATA_W-1:0] conv_data,
  output logic              busy,
  output logic [DATA_W-1:0] result,
  output logic              data_rdy
);

  import cnv_pkg::*;

  cnv_state_e state_q, state_d;
  logic       req_level, req_fall;
  logic       timer_done;
  logic       load_conv, load_acq, capture;

  cnv_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .req_n_i (start_n),
    .level_o (req_level),
    .fall_o  (req_fall)
  );

  cnv_timer #(.CONV_CYCLES(CONV_CYCLES), .ACQ_CYCLES(ACQ_CYCLES)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .load_conv_i (load_conv),
    .load_acq_i  (load_acq),
    .expired_o   (timer_done)
  );

  cnv_result_reg #(.DATA_W(DATA_W)) u_result (
    .clk       (clk),
    .rst       (rst),
    .capture_i (capture),
    .data_i    (conv_data),
    .result_o  (result),
    .rdy_o     (data_rdy)
  );

  always_comb begin
    state_d   = state_q;
    load_conv = 1'b0;
    load_acq  = 1'b0;
    capture   = 1'b0;
    unique case (state_q)
      ST_ACQ: begin
        if (timer_done) begin
          if (impulse_en && !req_level && !pwr_dn) begin
            state_d   = ST_CONV;
            load_conv = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_IDLE: begin
        if (req_fall && !pwr_dn) begin
          state_d   = ST_CONV;
          load_conv = 1'b1;
        end
      end
      ST_CONV: begin
        if (timer_done) begin
          state_d  = ST_ACQ;
          load_acq = 1'b1;
          capture  = 1'b1;
        end
      end
      default: state_d = ST_ACQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ACQ;
      busy    <= 1'b0;
    end else begin
      state_q <= state_d;
      busy    <= (state_d == ST_CONV);
    end
  end

endmodule

// File: rtl/cnv_sequencer_chk.sv
module cnv_sequencer_chk #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CONV_CYCLES = 18,
  parameter int unsigned ACQ_CYCLES  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              pwr_dn,
  input logic [DATA_W-1:0] conv_data,
  input logic              busy,
  input logic [DATA_W-1:0] result,
  input logic              data_rdy
);

  logic [15:0] high_run_q;
  logic [15:0] low_run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      high_run_q <= '0;
      low_run_q  <= '0;
    end else begin
      high_run_q <= busy ? ((high_run_q == 16'hFFFF) ? high_run_q : high_run_q + 1'b1) : '0;
      low_run_q  <= busy ? '0 : ((low_run_q == 16'hFFFF) ? low_run_q : low_run_q + 1'b1);
    end
  end

  // R3
  rdy_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    data_rdy |-> (!busy && $past(busy)));

  // R3
  rdy_single_chk: assert property (@(posedge clk) disable iff (rst)
    data_rdy |=> !data_rdy);

  // R3
  rdy_data_chk: assert property (@(posedge clk) disable iff (rst)
    data_rdy |-> (result == $past(conv_data)));

  // R4
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !data_rdy |-> $stable(result));

  // R2
  busy_max_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (high_run_q < 16'(CONV_CYCLES)));

  // R2
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> (high_run_q == 16'(CONV_CYCLES)));

  // R6
  acq_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (low_run_q >= 16'(ACQ_CYCLES)));

  // R9
  pd_block_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(pwr_dn));

  // R7
  abort_clear_chk: assert property (@(posedge clk)
    rst |=> (!busy && !data_rdy));

endmodule

bind cnv_sequencer cnv_sequencer_chk #(
  .DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES), .ACQ_CYCLES(ACQ_CYCLES)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .pwr_dn    (pwr_dn),
  .conv_data (conv_data),
  .busy      (busy),
  .result    (result),
  .data_rdy  (data_rdy)
);

// File: tb/cnv_sequencer_tb_top.sv
module cnv_sequencer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 16;
  localparam int CONV       = 18;
  localparam int ACQ        = 6;
  localparam int SYNC       = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_n = 1'b1;
  logic              pwr_dn = 1'b0;
  logic              impulse_en = 1'b0;
  logic [DATA_W-1:0] conv_data = '0;
  logic              busy;
  logic [DATA_W-1:0] result;
  logic              data_rdy;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cnv_sequencer #(.DATA_W(DATA_W), .CONV_CYCLES(CONV), .ACQ_CYCLES(ACQ),
                  .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst(rst), .start_n(start_n), .pwr_dn(pwr_dn),
    .impulse_en(impulse_en), .conv_data(conv_data),
    .busy(busy), .result(result), .data_rdy(data_rdy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // Waits for busy high, returns edges waited (capped).
  task automatic wait_busy(output int lat);
    lat = 0;
    while (!busy && lat < 200) begin tick(); lat++; end
  endtask

  // At first busy-high sample: returns number of busy samples, ends at first low sample.
  task automatic measure_busy(output int w);
    w = 0;
    while (busy && w < 200) begin w++; tick(); end
  endtask

  task automatic t_reset;
    check("R7 reset busy", busy, 0);
    check("R7 reset data_rdy", data_rdy, 0);
  endtask

  task automatic t_single(input logic [15:0] val);
    int lat, w;
    conv_data = val;
    start_n = 1'b0;
    wait_busy(lat);
    check("R1 start latency", lat, SYNC + 1);
    measure_busy(w);
    start_n = 1'b1;
    check("R2 busy width", w, CONV);
    check("R3 rdy at fall", data_rdy, 1);
    check("R3 result", result, val);
    tick();
    check("R3 rdy one cycle", data_rdy, 0);
    tick(ACQ + 4);
  endtask

  task automatic t_ignore_busy;
    int lat, w, pulses;
    conv_data = 16'h5A5A;
    start_n = 1'b0;
    wait_busy(lat);
    w = 0; pulses = 0;
    for (int i = 0; i < 6; i++) begin
      start_n = i[0] ? 1'b0 : 1'b1;
      w++; tick();
    end
    start_n = 1'b1;
    while (busy && w < 200) begin w++; tick(); end
    check("R5 width with edges during busy", w, CONV);
    for (int i = 0; i < CONV + ACQ + 10; i++) begin
      if (data_rdy) pulses++;
      if (i > 0 && busy) pulses += 100;
      tick();
    end
    check("R5 single conversion", pulses, 1);
  endtask

  task automatic t_acq_ignore_no_impulse;
    int lat, w, hits;
    impulse_en = 1'b0;
    conv_data = 16'h1234;
    start_n = 1'b0;
    wait_busy(lat);
    measure_busy(w);
    start_n = 1'b1;
    tick();
    start_n = 1'b0;           // edge lands inside acquisition, then held low
    hits = 0;
    for (int i = 0; i < CONV + 10; i++) begin
      if (busy) hits++;
      tick();
    end
    check("R6 edge in acquisition ignored", hits, 0);
    check("R11 held low without impulse", busy, 0);
    start_n = 1'b1;
    tick(4);
  endtask

  task automatic t_abort;
    int lat, hits;
    logic [15:0] old;
    old = result;
    conv_data = 16'hDEAD;
    start_n = 1'b0;
    wait_busy(lat);
    tick(5);
    rst = 1'b1;
    tick();
    check("R7 abort busy low", busy, 0);
    check("R7 abort no rdy", data_rdy, 0);
    rst = 1'b0;
    start_n = 1'b1;
    hits = 0;
    for (int i = 0; i < CONV + 4; i++) begin
      if (data_rdy || busy) hits++;
      tick();
    end
    check("R7 no strobe after abort", hits, 0);
    check("R7 result retained", result, old);
  endtask

  task automatic t_powerdown;
    int lat, w, hits;
    conv_data = 16'hBEEF;
    start_n = 1'b0;
    wait_busy(lat);
    pwr_dn = 1'b1;
    measure_busy(w);
    start_n = 1'b1;
    check("R8 width under power-down", w, CONV - 0);
    check("R8 rdy under power-down", data_rdy, 1);
    check("R8 result under power-down", result, 16'hBEEF);
    tick(ACQ + 4);
    start_n = 1'b0;
    impulse_en = 1'b1;
    hits = 0;
    for (int i = 0; i < CONV + 10; i++) begin
      if (busy) hits++;
      tick();
    end
    check("R9 no start in power-down", hits, 0);
    start_n = 1'b1;
    impulse_en = 1'b0;
    pwr_dn = 1'b0;
    tick(4);
  endtask

  task automatic t_impulse;
    int lat, w, gap, hits;
    impulse_en = 1'b1;
    conv_data = 16'h0F0F;
    start_n = 1'b0;
    wait_busy(lat);
    measure_busy(w);
    check("R10 first result", result, 16'h0F0F);
    conv_data = 16'hF0F0;
    gap = 0;
    while (!busy && gap < 200) begin gap++; tick(); end
    check("R10 gap equals acquisition", gap, ACQ);
    start_n = 1'b1;
    measure_busy(w);
    check("R10 second width", w, CONV);
    check("R10 second result", result, 16'hF0F0);
    hits = 0;
    for (int i = 0; i < CONV; i++) begin
      if (busy) hits++;
      tick();
    end
    check("R10 no restart when released", hits, 0);
    impulse_en = 1'b0;
  endtask

  initial begin
    tick(3);
    t_reset();
    rst = 1'b0;
    tick(ACQ + 4);
    t_single(16'hA5C3);
    t_single(16'h0001);
    t_ignore_busy();
    t_acq_ignore_no_impulse();
    t_abort();
    t_powerdown();
    t_impulse();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule